// File: doc/BRIEF.md
# Key-Protected Operating Mode Controller

This block moves a system between its operating modes under software control. Software asks for a new mode by writing twice to a request register. The first write carries an arming key and the second carries its bitwise inverse, and both name the same target mode. Each mode has its own configuration word. The word picks the system clock source and says which clock sources are powered, how the two flash arrays are powered, whether the main regulator runs and whether the pads are powered down. A mode-enable register decides which modes may be entered.

Once a request is accepted, the transition sequencer works in three steps. First it powers up every clock source the target needs and keeps the old sources running. It then waits for all of the needed sources to report ready, and only after that moves the system-clock select. One cycle later it drops the sources the target no longer uses and applies the target's power settings. A status word reports the current mode, a busy flag, a latched internal-oscillator-ready flag and a sticky error flag that records refused requests. The analog sources are not part of the block: they appear only as ready inputs and enable outputs.

Top module: `pmc_mode_ctrl`

## Requirements
- R1: After reset the current mode is 3 (DRUN) and busy and error are 0. The outputs follow the reset configuration word 0x1F0010: clk_sel=0, src_en=4'b0001, both flash fields 3, mreg_on=1, pad_pwrdn=0.
- R2: The status flag at bit 9 latches once src_ready[0] (internal oscillator) has been seen high at a clock edge. Until then, writes to the request register are ignored.
- R3: Address 1 is the request register. A write with 0x5AF0 in bits 15:0 arms the request with the mode in bits 31:28. The next request write with 0xA50F and the same mode starts a transition. Status at address 0 shows the current mode in bits 3:0 and busy in bit 8. Busy is 1 from the edge that accepts the second write until the mode is applied. A lone 0xA50F write with nothing armed has no effect.
- R4: Mode codes are TEST 1, SAFE 2, DRUN 3, RUN0..RUN3 4..7, HALT0 8 and STOP0 10. In the enable register at address 2, bit n enables mode n. Bits 0, 2, 3 and 4 always read 1. Only bits 1, 5..8 and 10 are writable. A request for a disabled mode, or for code 0, 9 or 11..15, is refused.
- R5: While armed, a request write that does not carry 0x5AF0 and does not start a transition is refused: a wrong key or a different mode field. A refusal disarms, leaves the mode unchanged and sets the sticky error bit 12 of status. Writing 1 to bit 12 at address 0 clears it.
- R6: src_en bits are 0 internal oscillator, 1 crystal oscillator, 2 PLL0, 3 PLL1, and src_ready uses the same order. On acceptance the target's sources are ORed into src_en. clk_sel changes only at the edge after every target source is ready. One edge later src_en becomes exactly the target's set.
- R7: The configuration word of mode n is at address 16+n, and only valid codes hold storage (others read 0). The fields are: clock select in bits 3:0 (0 internal oscillator, 2 crystal, 4 PLL0, 5 PLL1, 15 off), source enables in bits 7:4 (in the same order as R6), code-flash power in bits 17:16, data-flash power in bits 19:18, regulator in bit 20 and pad power-down in bit 23. Other bits read 0. The power outputs and the mode change together with the final src_en.
- R8: Requesting the mode already active is accepted and applies that mode's configuration word as currently written.
- R9: Writes to the request register while busy are ignored: no transition, no error and no arming.
- R10: The target configuration is captured when the request is accepted. Editing the target's configuration word during the transition does not change what that transition applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| src_ready | input | 4 | Ready flags of the four clock sources |
| src_en | output | 4 | Power enables of the four clock sources |
| clk_sel | output | 4 | System clock source select |
| cflash_pwr | output | 2 | Code-flash power level |
| dflash_pwr | output | 2 | Data-flash power level |
| mreg_on | output | 1 | Main regulator enable |
| pad_pwrdn | output | 1 | Pad power-down |

## Verification
The bench first holds the new sources' ready inputs low after a request. A design that switched the clock select early, or dropped the old source before the switch, would show clk_sel or src_en differing from the model in the waiting cycles. It also sends wrong keys, mismatched mode fields, disabled modes and the unused codes 0 and 9. A design that failed to refuse any of these would change mode or leave the error bit clear. Finally it requests a mode during a transition and edits the target's configuration word mid-flight. A design that accepted either would end in the wrong mode or apply the edited word instead of the captured one.

// File: rtl/pmc_pkg.sv
// Package: constants, field layout and state type shared by the mode controller.
// Assumes a 5-bit word address space and 32-bit data.
package pmc_pkg;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 5;
    localparam int CODE_W    = 4;
    localparam int NUM_CODES = 1 << CODE_W;
    localparam int CFG_W     = 24;
    localparam int EN_W      = 11;
    localparam int SRC_N     = 4;
    localparam int KEY_W     = 16;

    localparam logic [KEY_W-1:0] KEY_ARM  = 16'h5AF0;
    localparam logic [KEY_W-1:0] KEY_FIRE = 16'hA50F;

    localparam logic [CODE_W-1:0]    MODE_BOOT = 4'd3;
    localparam logic [NUM_CODES-1:0] MODE_OK   = 16'h05FE;

    localparam logic [CFG_W-1:0] CFG_MASK = 24'h9F00FF;
    localparam logic [CFG_W-1:0] CFG_INIT = 24'h1F0010;
    localparam logic [EN_W-1:0]  EN_FIXED = 11'h01D;
    localparam logic [EN_W-1:0]  EN_RW    = 11'h5E2;

    localparam logic [ADDR_W-1:0] ADR_STATUS = 5'd0;
    localparam logic [ADDR_W-1:0] ADR_REQ    = 5'd1;
    localparam logic [ADDR_W-1:0] ADR_ENABLE = 5'd2;

    localparam int ST_BUSY = 8;
    localparam int ST_IRC  = 9;
    localparam int ST_ERR  = 12;

    typedef enum logic [1:0] {SQ_IDLE, SQ_WAIT, SQ_COMMIT} seq_state_t;

    typedef struct packed {
        logic       pad_pd;
        logic [1:0] spare_hi;
        logic       mreg_on;
        logic [1:0] dflash;
        logic [1:0] cflash;
        logic [7:0] spare_lo;
        logic [3:0] src_on;
        logic [3:0] clk_sel;
    } mode_cfg_t;
endpackage

// File: rtl/pmc_regs.sv
// Module: mode-enable register and per-mode configuration words.
// Decodes its own addresses from the shared write strobe; storage exists
// only for requestable mode codes. Read data is combinational.
module pmc_regs
    import pmc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wdata,
    input  logic [CODE_W-1:0]    look_mode,
    output logic [NUM_CODES-1:0] en_view,
    output mode_cfg_t            look_cfg,
    output logic [DATA_W-1:0]    rd_data
);
    logic [EN_W-1:0]  en_q;
    logic [CFG_W-1:0] cfg_w [NUM_CODES];

    // Writable mode-enable bits; fixed bits are merged on the read side.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= '0;
        else if (wr_en && addr == ADR_ENABLE)
            en_q <= wdata[EN_W-1:0] & EN_RW;
    end

    assign en_view = {{(NUM_CODES-EN_W){1'b0}}, en_q | EN_FIXED};

    generate
        for (genvar g = 0; g < NUM_CODES; g++) begin : g_cfg
            if (MODE_OK[g]) begin : g_live
                logic [CFG_W-1:0] q;
                // Configuration word of one requestable mode.
                always_ff @(posedge clk) begin
                    if (!rst_n)
                        q <= CFG_INIT;
                    else if (wr_en && addr == {1'b1, CODE_W'(g)})
                        q <= wdata[CFG_W-1:0] & CFG_MASK;
                end
                assign cfg_w[g] = q;
            end else begin : g_none
                assign cfg_w[g] = '0;
            end
        end
    endgenerate

    assign look_cfg = mode_cfg_t'(cfg_w[look_mode]);

    // Read mux for the addresses owned here.
    always_comb begin
        rd_data = '0;
        if (addr[ADDR_W-1])
            rd_data = {{(DATA_W-CFG_W){1'b0}}, cfg_w[addr[CODE_W-1:0]]};
        else if (addr == ADR_ENABLE)
            rd_data = {{(DATA_W-NUM_CODES){1'b0}}, en_view};
    end
endmodule

// File: rtl/pmc_keygate.sv
// Module: two-write key check on the request register.
// Assumes req_wr is already decoded to the request address; hold blocks
// every effect of a write (busy or oscillator not yet stable).
module pmc_keygate
    import pmc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_wr,
    input  logic [DATA_W-1:0]    req_data,
    input  logic                 hold,
    input  logic [NUM_CODES-1:0] en_view,
    output logic                 fire,
    output logic [CODE_W-1:0]    fire_mode,
    output logic                 abort
);
    logic              armed_q;
    logic [CODE_W-1:0] arm_mode_q;
    logic [KEY_W-1:0]  key;
    logic              live, is_arm, target_ok;

    assign key       = req_data[KEY_W-1:0];
    assign fire_mode = req_data[DATA_W-1 -: CODE_W];
    assign live      = req_wr && !hold;
    assign is_arm    = (key == KEY_ARM);
    assign target_ok = MODE_OK[fire_mode] && en_view[fire_mode];
    assign fire      = live && armed_q && !is_arm && key == KEY_FIRE &&
                       fire_mode == arm_mode_q && target_ok;
    assign abort     = live && armed_q && !is_arm && !fire;

    // Arm on the first key, disarm on any other accepted request write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q    <= 1'b0;
            arm_mode_q <= '0;
        end else if (live) begin
            armed_q <= is_arm;
            if (is_arm)
                arm_mode_q <= fire_mode;
        end
    end
endmodule

// File: rtl/pmc_seq.sv
// Module: transition sequencer. Powers the target's sources on, waits for
// their ready flags, moves the clock select, then commits the target set
// and power settings. Assumes go is only raised while idle.
module pmc_seq
    import pmc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [CODE_W-1:0] go_mode,
    input  mode_cfg_t         go_cfg,
    input  logic [SRC_N-1:0]  src_ready,
    output logic              busy,
    output logic [CODE_W-1:0] mode,
    output logic [SRC_N-1:0]  src_en,
    output logic [3:0]        clk_sel,
    output logic [1:0]        cflash,
    output logic [1:0]        dflash,
    output logic              mreg_on,
    output logic              pad_pd,
    output logic [SRC_N-1:0]  need_on
);
    localparam mode_cfg_t BOOT_CFG = mode_cfg_t'(CFG_INIT);

    seq_state_t        state_q;
    mode_cfg_t         tgt_q, applied_q;
    logic [CODE_W-1:0] tgt_mode_q, mode_q;
    logic [SRC_N-1:0]  src_en_q;
    logic [3:0]        sel_q;
    logic              all_ready;

    assign all_ready = (src_ready & tgt_q.src_on) == tgt_q.src_on;

    // Three-step transition: capture and power up, switch, commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= SQ_IDLE;
            tgt_q      <= BOOT_CFG;
            applied_q  <= BOOT_CFG;
            tgt_mode_q <= MODE_BOOT;
            mode_q     <= MODE_BOOT;
            src_en_q   <= BOOT_CFG.src_on;
            sel_q      <= BOOT_CFG.clk_sel;
        end else begin
            case (state_q)
                SQ_IDLE: if (go) begin
                    tgt_q      <= go_cfg;
                    tgt_mode_q <= go_mode;
                    src_en_q   <= src_en_q | go_cfg.src_on;
                    state_q    <= SQ_WAIT;
                end
                SQ_WAIT: if (all_ready) begin
                    sel_q   <= tgt_q.clk_sel;
                    state_q <= SQ_COMMIT;
                end
                SQ_COMMIT: begin
                    src_en_q  <= tgt_q.src_on;
                    applied_q <= tgt_q;
                    mode_q    <= tgt_mode_q;
                    state_q   <= SQ_IDLE;
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    assign busy    = (state_q != SQ_IDLE);
    assign mode    = mode_q;
    assign src_en  = src_en_q;
    assign clk_sel = sel_q;
    assign cflash  = applied_q.cflash;
    assign dflash  = applied_q.dflash;
    assign mreg_on = applied_q.mreg_on;
    assign pad_pd  = applied_q.pad_pd;
    assign need_on = tgt_q.src_on;
endmodule

// File: rtl/pmc_mode_ctrl.sv
// Module: top of the key-protected operating mode controller.
// Holds the oscillator-stable and error flags, composes the status word and
// ties together registers, key gate and sequencer.
module pmc_mode_ctrl
    import pmc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [4:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [3:0]        src_ready,
    output logic [3:0]        src_en,
    output logic [3:0]        clk_sel,
    output logic [1:0]        cflash_pwr,
    output logic [1:0]        dflash_pwr,
    output logic              mreg_on,
    output logic              pad_pwrdn
);
    logic                 irc_ok, err, busy, fire, abort;
    logic [CODE_W-1:0]    cur_mode, fire_mode;
    logic [NUM_CODES-1:0] en_view;
    logic [SRC_N-1:0]     need_on;
    logic [DATA_W-1:0]    reg_rd, status;
    mode_cfg_t            look_cfg;

    // Latch the internal oscillator ready flag once seen after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irc_ok <= 1'b0;
        else if (src_ready[0])
            irc_ok <= 1'b1;
    end

    // Sticky refusal flag, cleared by writing one to its status bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err <= 1'b0;
        else if (abort)
            err <= 1'b1;
        else if (bus_wr && bus_addr == ADR_STATUS && bus_wdata[ST_ERR])
            err <= 1'b0;
    end

    // Status word and top-level read mux.
    always_comb begin
        status              = '0;
        status[CODE_W-1:0]  = cur_mode;
        status[ST_BUSY]     = busy;
        status[ST_IRC]      = irc_ok;
        status[ST_ERR]      = err;
        bus_rdata = (bus_addr == ADR_STATUS) ? status : reg_rd;
    end

    pmc_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .look_mode(fire_mode), .en_view(en_view),
        .look_cfg(look_cfg), .rd_data(reg_rd)
    );

    pmc_keygate u_key (
        .clk(clk), .rst_n(rst_n),
        .req_wr(bus_wr && bus_addr == ADR_REQ), .req_data(bus_wdata),
        .hold(busy || !irc_ok), .en_view(en_view),
        .fire(fire), .fire_mode(fire_mode), .abort(abort)
    );

    pmc_seq u_seq (
        .clk(clk), .rst_n(rst_n), .go(fire), .go_mode(fire_mode),
        .go_cfg(look_cfg), .src_ready(src_ready), .busy(busy),
        .mode(cur_mode), .src_en(src_en), .clk_sel(clk_sel),
        .cflash(cflash_pwr), .dflash(dflash_pwr), .mreg_on(mreg_on),
        .pad_pd(pad_pwrdn), .need_on(need_on)
    );
endmodule

// File: rtl/pmc_mode_ctrl_chk.sv
// Checker: temporal properties of the mode controller, bound to its top.
module pmc_mode_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_wr,
    input logic [4:0]  bus_addr,
    input logic [31:0] bus_wdata,
    input logic        busy,
    input logic        irc_ok,
    input logic        err,
    input logic [3:0]  cur_mode,
    input logic [3:0]  clk_sel,
    input logic [3:0]  src_en,
    input logic [3:0]  src_ready,
    input logic [3:0]  need_on
);
    a_r2_no_busy_before_irc: assert property (@(posedge clk) disable iff (!rst_n)
        !irc_ok |-> !busy);

    a_r3_busy_needs_fire_key: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(bus_wr && bus_addr == 5'd1 && bus_wdata[15:0] == 16'hA50F));

    a_r5_err_clears_by_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err) |-> $past(bus_wr && bus_addr == 5'd0 && bus_wdata[12]));

    a_r5_refusal_not_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> !$rose(busy));

    a_r6_switch_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel != $past(clk_sel)) |-> $past(busy && ((src_ready & need_on) == need_on)));

    a_r6_no_drop_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ((src_en & $past(src_en)) == $past(src_en)));

    a_r7_mode_moves_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode != $past(cur_mode)) |-> ($past(busy) && !busy));
endmodule

bind pmc_mode_ctrl pmc_mode_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .busy(busy), .irc_ok(irc_ok), .err(err),
    .cur_mode(cur_mode), .clk_sel(clk_sel), .src_en(src_en),
    .src_ready(src_ready), .need_on(need_on)
);

// File: tb/sim_pmc_mode_ctrl.sv
// Bench: behavioural cycle model compared with the outputs every clock,
// plus directed register reads.
module sim_pmc_mode_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  src_ready = 4'b0000;
    logic [3:0]  src_en, clk_sel;
    logic [1:0]  cflash_pwr, dflash_pwr;
    logic        mreg_on, pad_pwrdn;

    int errors = 0;
    int checks = 0;
    bit live_cmp = 1'b0;

    always #2 clk = ~clk;

    pmc_mode_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_ready(src_ready),
        .src_en(src_en), .clk_sel(clk_sel), .cflash_pwr(cflash_pwr),
        .dflash_pwr(dflash_pwr), .mreg_on(mreg_on), .pad_pwrdn(pad_pwrdn)
    );

    // ---------------- reference model ----------------
    int m_mode, m_busy, m_phase, m_tgt, m_tcfg, m_armed, m_amode;
    int m_err, m_irc, m_en, m_src, m_sel, m_pow;
    int m_cfg [16];

    function automatic bit valid_code(int c);
        return (c >= 1 && c <= 8) || c == 10;
    endfunction

    function automatic int mread(int a);
        if (a == 0) return (m_err << 12) | (m_irc << 9) | (m_busy << 8) | m_mode;
        if (a == 2) return m_en | 'h1D;
        if (a >= 16) return m_cfg[a-16];
        return 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 3; m_busy = 0; m_phase = 0; m_tgt = 3; m_tcfg = 'h1F0010;
            m_armed = 0; m_amode = 0; m_err = 0; m_irc = 0; m_en = 0;
            m_src = 1; m_sel = 0; m_pow = 'h1F0010;
            for (int i = 0; i < 16; i++) m_cfg[i] = valid_code(i) ? 'h1F0010 : 0;
        end else begin
            int old_irc, old_busy, key, md, on;
            old_irc = m_irc; old_busy = m_busy;
            if (m_phase == 2) begin
                m_src = (m_tcfg >> 4) & 'hF; m_pow = m_tcfg; m_mode = m_tgt;
                m_busy = 0; m_phase = 0;
            end else if (m_phase == 1) begin
                on = (m_tcfg >> 4) & 'hF;
                if ((int'(src_ready) & on) == on) begin
                    m_sel = m_tcfg & 'hF; m_phase = 2;
                end
            end
            if (bus_wr) begin
                if (bus_addr == 0 && bus_wdata[12]) m_err = 0;
                else if (bus_addr == 2) m_en = int'(bus_wdata) & 'h5E2;
                else if (bus_addr >= 16 && valid_code(bus_addr - 16))
                    m_cfg[bus_addr-16] = int'(bus_wdata) & 'h9F00FF;
                else if (bus_addr == 1 && old_irc == 1 && old_busy == 0) begin
                    key = int'(bus_wdata[15:0]); md = int'(bus_wdata[31:28]);
                    if (key == 'h5AF0) begin
                        m_armed = 1; m_amode = md;
                    end else if (m_armed == 1) begin
                        m_armed = 0;
                        if (key == 'hA50F && md == m_amode && valid_code(md) &&
                            (((m_en | 'h1D) >> md) & 1) == 1) begin
                            m_tgt = md; m_tcfg = m_cfg[md]; m_busy = 1; m_phase = 1;
                            m_src = m_src | ((m_tcfg >> 4) & 'hF);
                        end else m_err = 1;
                    end
                end
            end
            if (src_ready[0]) m_irc = 1;
        end
    end

    // ---------------- checking ----------------
    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (live_cmp) begin
            check("R6 src_en", int'(src_en), m_src);
            check("R6 clk_sel", int'(clk_sel), m_sel);
            check("R7 power outputs",
                  int'({pad_pwrdn, mreg_on, dflash_pwr, cflash_pwr}),
                  (((m_pow >> 23) & 1) << 5) | (((m_pow >> 20) & 1) << 4) |
                  (((m_pow >> 18) & 3) << 2) | ((m_pow >> 16) & 3));
        end
    end

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, input string tag);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(tag, int'(bus_rdata), mread(int'(a)));
    endtask

    task automatic request(input logic [3:0] md);
        wr(5'd1, {md, 12'h000, 16'h5AF0});
        wr(5'd1, {md, 12'h000, 16'hA50F});
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        live_cmp = 1'b1;
        // R1 reset state
        check("R1 status", int'(bus_rdata), 3);
        check("R1 src_en", int'(src_en), 1);
        check("R1 power", int'({pad_pwrdn, mreg_on, dflash_pwr, cflash_pwr}), 'h1F);
        rd(5'd20, "R7 reset config word");

        // R2 requests ignored before the internal oscillator is ready
        request(4'd4);
        idle(4);
        rd(5'd0, "R2 ignored before irc");
        check("R2 mode unchanged", int'(bus_rdata[3:0]), 3);
        src_ready = 4'b0001;
        idle(2);
        rd(5'd0, "R2 irc flag");
        check("R2 irc bit", int'(bus_rdata[9]), 1);

        // R3/R6 DRUN to RUN0 with staged ready flags
        wr(5'd20, 32'h001F0074);
        rd(5'd20, "R7 config readback");
        request(4'd4);
        idle(4);
        rd(5'd0, "R3 busy while waiting");
        check("R3 busy bit", int'(bus_rdata[8]), 1);
        check("R6 select held", int'(clk_sel), 0);
        src_ready = 4'b0011;
        idle(3);
        src_ready = 4'b0111;
        idle(4);
        rd(5'd0, "R3 mode RUN0");
        check("R3 mode code", int'(bus_rdata[3:0]), 4);
        check("R6 final sources", int'(src_en), 'b0111);

        // R8 same-mode request applies the edited word
        wr(5'd20, 32'h001D0054);
        request(4'd4);
        idle(4);
        check("R8 reapplied sources", int'(src_en), 'b0101);
        check("R8 reapplied cflash", int'(cflash_pwr), 1);

        // R3 lone fire key without arming
        wr(5'd1, 32'h3000A50F);
        idle(2);
        rd(5'd0, "R3 lone fire key ignored");

        // R5 refusals
        wr(5'd1, 32'h30005AF0);
        wr(5'd1, 32'h30001234);
        rd(5'd0, "R5 wrong key");
        check("R5 err bit", int'(bus_rdata[12]), 1);
        wr(5'd0, 32'h00001000);
        rd(5'd0, "R5 w1c clear");
        wr(5'd1, 32'h30005AF0);
        wr(5'd1, 32'h5000A50F);
        rd(5'd0, "R5 mode mismatch");
        wr(5'd0, 32'h00001000);

        // R4 disabled and unused codes
        request(4'd5);
        rd(5'd0, "R4 disabled RUN1 refused");
        check("R4 mode kept", int'(bus_rdata[3:0]), 4);
        wr(5'd0, 32'h00001000);
        request(4'd9);
        rd(5'd0, "R4 code 9 refused");
        wr(5'd0, 32'h00001000);
        request(4'd0);
        rd(5'd0, "R4 code 0 refused");
        wr(5'd0, 32'h00001000);
        wr(5'd2, 32'hFFFFFFFF);
        rd(5'd2, "R4 enable all");
        check("R4 enable value", int'(bus_rdata), 'h5FF);
        wr(5'd2, 32'h0);
        rd(5'd2, "R4 fixed enables");
        wr(5'd25, 32'hFFFFFFFF);
        rd(5'd25, "R7 unused code has no word");

        // R9/R10 RUN1 with a request and an edit during the transition
        wr(5'd2, 32'h20);
        wr(5'd21, 32'h001A0095);
        src_ready = 4'b0101;
        request(4'd5);
        request(4'd3);
        wr(5'd21, 32'h0);
        idle(2);
        rd(5'd0, "R9 busy, no error");
        src_ready = 4'b1111;
        idle(4);
        rd(5'd0, "R9 ended in RUN1");
        check("R9 mode code", int'(bus_rdata[3:0]), 5);
        check("R10 captured sources", int'(src_en), 'b1001);
        check("R10 captured select", int'(clk_sel), 5);
        rd(5'd21, "R10 edited word stored");

        // R7 SAFE with pad power-down
        wr(5'd18, 32'h00800010);
        request(4'd2);
        idle(4);
        check("R7 pad power-down", int'(pad_pwrdn), 1);
        check("R7 regulator off", int'(mreg_on), 0);

        // R8 DRUN then DRUN again with a new word
        request(4'd3);
        idle(4);
        wr(5'd19, 32'h001F0032);
        request(4'd3);
        idle(4);
        rd(5'd0, "R8 DRUN to DRUN");
        check("R8 select crystal", int'(clk_sel), 2);
        check("R8 sources", int'(src_en), 'b0011);

        live_cmp = 1'b0;
        summary();
        $finish;
    end
endmodule